// File: doc/BRIEF.md
# Line Clock Loss-of-Lock Monitor

This block watches a recovered DS3 line clock (nominally 44.736 MHz) and checks its frequency against a local reference clock of the same nominal rate. It counts recovered-clock edges over a fixed window of reference-clock cycles. When the count is off by more than 0.5% (5000 ppm), it declares a loss-of-lock defect. While the defect stands, a select output tells the downstream clock mux to use the reference clock instead of the recovered one. That keeps framing logic supplied with a line-rate clock. The defect is withdrawn only after two in-tolerance windows in a row.

On the system clock side, a small read port exposes two registers. One shows live condition levels: loss of lock, plus three further line conditions that come in as inputs. The other holds one change-of-condition interrupt bit per condition, and those bits clear when the register is read. An interrupt line is raised for any set interrupt bit whose enable bit is high.

Top module: `lol_monitor`

## Requirements
- R1: After reset, sel_ref_o, lol_o and irq_o are 0, and both registers read 0x00 while the recovered clock runs at the reference rate and cond_i is 0.
- R2: A window lasts 2^WIN_LOG2 reference cycles. A window whose recovered-edge count differs from 2^WIN_LOG2 by no more than floor(2^WIN_LOG2*PPM/10^6) is in tolerance. A clock 0.2% slow raises no defect.
- R3: A window out of tolerance, whether the clock is slow or fast, declares the defect at that window's end. sel_ref_o then goes to 1 (1 selects the reference clock), and lol_o follows through a two-flop system-clock synchronizer.
- R4: sel_ref_o changes only on the reference-clock edge that ends a window.
- R5: The defect clears only at the end of the second consecutive in-tolerance window, and sel_ref_o then returns to 0. One window after the line recovers, the defect is still declared.
- R6: A stopped recovered clock (zero count) is out of tolerance and declares the defect.
- R7: A read at rd_addr_i=0 returns the live status. Bit 0 is cond_i[0] (DMO), bit 1 is cond_i[1] (LOS), bit 2 is the loss-of-lock defect and bit 3 is cond_i[2] (FL). rd_data_o is valid on the system edge that samples rd_en_i.
- R8: A read at rd_addr_i=1 returns the interrupt bits, in the same bit positions as the status register. Each bit is set by any change of its status bit in either direction. A read clears the bits it returned, but a change in the same cycle keeps its bit set.
- R9: irq_o is the OR of the interrupt bits ANDed with irq_en_i, registered one system cycle later. With irq_en_i at 0, irq_o stays 0.
- R10: Bits 7 to 4 of rd_data_o always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rec_clk_i | input | 1 | Recovered line clock |
| ref_clk_i | input | 1 | Reference clock, same nominal rate |
| sys_clk_i | input | 1 | Register and interrupt clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 3 | Other line conditions: [0] DMO, [1] LOS, [2] FL (system domain) |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 1 | 0 = status, 1 = interrupt status |
| irq_en_i | input | 4 | Per-bit interrupt enable |
| rd_data_o | output | 8 | Read data |
| sel_ref_o | output | 1 | 1 = downstream uses reference clock (reference domain) |
| lol_o | output | 1 | Live defect, system domain |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the clearing rule. The line recovers at a point unrelated to the window boundaries, so the window that spans the change can go either way. The bench restores the clock and samples sel_ref_o at 0.9 window, when at most one boundary has passed, so the defect must still be declared. It samples again at 3.5 windows, when two full good windows must have ended. The slow, fast and stopped cases are made by changing the recovered clock's half period in the bench, or by gating it, with a shortened window parameter.

// File: rtl/lol_mon_pkg.sv
package lol_mon_pkg;
  localparam int unsigned BIT_DMO = 0;
  localparam int unsigned BIT_LOS = 1;
  localparam int unsigned BIT_LOL = 2;
  localparam int unsigned BIT_FL  = 3;
  localparam int unsigned NCOND   = 4;
  localparam int unsigned DATA_W  = 8;

  typedef enum logic {
    ADDR_STAT = 1'b0,
    ADDR_INT  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/lol_edge_cnt.sv
// Free-running recovered-clock edge counter, Gray-coded for crossing.
module lol_edge_cnt #(
  parameter int unsigned CW = 18
) (
  input  logic          rec_clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] gray_o
);
  logic [CW-1:0] bin_q, bin_nx;

  assign bin_nx = bin_q + CW'(1);

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/lol_meter.sv
// Reference-domain window timer, frequency comparison and defect state.
module lol_meter #(
  parameter int unsigned     WIN_LOG2 = 16,
  parameter longint unsigned PPM      = 5000,
  parameter int unsigned     CLR_WINS = 2,
  parameter int unsigned     CW       = WIN_LOG2 + 2
) (
  input  logic          ref_clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] gray_i,
  output logic          lol_o,
  output logic          win_end_o,
  output logic          oot_o
);
  localparam longint unsigned WIN_LEN = 64'd1 << WIN_LOG2;
  localparam longint unsigned TOL     = (WIN_LEN * PPM) / 64'd1000000;
  localparam logic [CW-1:0]   WIN_C   = CW'(WIN_LEN);
  localparam logic [CW-1:0]   TOL_C   = CW'(TOL);
  localparam int unsigned     GW      = $clog2(CLR_WINS + 1);

  logic [CW-1:0]       g_s1, g_s2, bin, prev_q, delta, diff;
  logic [WIN_LOG2-1:0] win_q;
  logic [GW-1:0]       good_q;
  logic                lol_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_s1 <= '0;
      g_s2 <= '0;
    end else begin
      g_s1 <= gray_i;
      g_s2 <= g_s1;
    end
  end

  always_comb begin
    for (int i = 0; i < CW; i++) bin[i] = ^(g_s2 >> i);
  end

  assign win_end_o = &win_q;
  assign delta     = bin - prev_q;
  assign diff      = (delta >= WIN_C) ? (delta - WIN_C) : (WIN_C - delta);
  assign oot_o     = diff > TOL_C;  // zero count lands here too

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      prev_q <= '0;
      good_q <= '0;
      lol_q  <= 1'b0;
    end else begin
      win_q <= win_q + WIN_LOG2'(1);
      if (win_end_o) begin
        prev_q <= bin;
        if (oot_o) begin
          lol_q  <= 1'b1;
          good_q <= '0;
        end else if (lol_q) begin
          if (good_q == GW'(CLR_WINS - 1)) begin
            lol_q  <= 1'b0;
            good_q <= '0;
          end else begin
            good_q <= good_q + GW'(1);
          end
        end
      end
    end
  end

  assign lol_o = lol_q;
endmodule

// File: rtl/lol_regs.sv
// System-domain status, clear-on-read interrupt bits and read port.
module lol_regs
  import lol_mon_pkg::*;
(
  input  logic              sys_clk_i,
  input  logic              rst_ni,
  input  logic              lol_async_i,
  input  logic [2:0]        cond_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  input  logic [NCOND-1:0]  irq_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              lol_o,
  output logic [NCOND-1:0]  int_o,
  output logic [NCOND-1:0]  chg_o
);
  logic             lol_s1, lol_s2;
  logic [NCOND-1:0] stat, stat_q, int_q, clr;
  logic             rd_int;

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lol_s1 <= 1'b0;
      lol_s2 <= 1'b0;
    end else begin
      lol_s1 <= lol_async_i;
      lol_s2 <= lol_s1;
    end
  end

  always_comb begin
    stat          = '0;
    stat[BIT_DMO] = cond_i[0];
    stat[BIT_LOS] = cond_i[1];
    stat[BIT_LOL] = lol_s2;
    stat[BIT_FL]  = cond_i[2];
  end

  assign rd_int = rd_en_i && (reg_addr_e'(rd_addr_i) == ADDR_INT);
  assign chg_o  = stat ^ stat_q;
  assign clr    = rd_int ? int_q : '0;

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q    <= '0;
      int_q     <= '0;
      rd_data_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      stat_q <= stat;
      int_q  <= chg_o | (int_q & ~clr);  // new change beats the clear
      irq_o  <= |(int_q & irq_en_i);
      if (rd_en_i)
        rd_data_o <= {{(DATA_W-NCOND){1'b0}}, rd_int ? int_q : stat};
    end
  end

  assign lol_o = lol_s2;
  assign int_o = int_q;
endmodule

// File: rtl/lol_monitor.sv
module lol_monitor
  import lol_mon_pkg::*;
#(
  parameter int unsigned     WIN_LOG2 = 16,
  parameter longint unsigned PPM      = 5000,
  parameter int unsigned     CLR_WINS = 2
) (
  input  logic              rec_clk_i,
  input  logic              ref_clk_i,
  input  logic              sys_clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cond_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  input  logic [NCOND-1:0]  irq_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sel_ref_o,
  output logic              lol_o,
  output logic              irq_o
);
  localparam int unsigned CW = WIN_LOG2 + 2;

  logic [CW-1:0]    rec_gray;
  logic             win_end, oot;
  logic [NCOND-1:0] int_bits, chg_bits;

  lol_edge_cnt #(.CW(CW)) u_cnt (
    .rec_clk_i (rec_clk_i),
    .rst_ni    (rst_ni),
    .gray_o    (rec_gray)
  );

  lol_meter #(
    .WIN_LOG2 (WIN_LOG2),
    .PPM      (PPM),
    .CLR_WINS (CLR_WINS),
    .CW       (CW)
  ) u_meter (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .gray_i    (rec_gray),
    .lol_o     (sel_ref_o),
    .win_end_o (win_end),
    .oot_o     (oot)
  );

  lol_regs u_regs (
    .sys_clk_i   (sys_clk_i),
    .rst_ni      (rst_ni),
    .lol_async_i (sel_ref_o),
    .cond_i      (cond_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .irq_en_i    (irq_en_i),
    .rd_data_o   (rd_data_o),
    .irq_o       (irq_o),
    .lol_o       (lol_o),
    .int_o       (int_bits),
    .chg_o       (chg_bits)
  );
endmodule

// File: rtl/lol_monitor_chk.sv
module lol_monitor_chk (
  input logic       ref_clk_i,
  input logic       sys_clk_i,
  input logic       rst_ni,
  input logic       win_end_i,
  input logic       oot_i,
  input logic       sel_ref_i,
  input logic       rd_en_i,
  input logic       rd_addr_i,
  input logic [3:0] chg_i,
  input logic [3:0] int_bits_i,
  input logic [3:0] irq_en_i,
  input logic       irq_i,
  input logic [7:0] rd_data_i
);
  // R4
  sel_at_window_end_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(sel_ref_i));

  // R3
  declare_cause_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(sel_ref_i) |-> $past(win_end_i && oot_i));

  // R5
  clear_cause_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(sel_ref_i) |-> $past(win_end_i && !oot_i));

  // R8
  int_set_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (|chg_i) |=> ((int_bits_i & $past(chg_i)) == $past(chg_i)));

  // R8
  int_clear_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i) |=> ((int_bits_i & $past(int_bits_i & ~chg_i)) == 4'h0));

  // R9
  irq_masked_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (irq_en_i == 4'h0) |=> !irq_i);

  // R10
  unused_zero_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    rd_data_i[7:4] == 4'h0);
endmodule

bind lol_monitor lol_monitor_chk u_chk (
  .ref_clk_i  (ref_clk_i),
  .sys_clk_i  (sys_clk_i),
  .rst_ni     (rst_ni),
  .win_end_i  (win_end),
  .oot_i      (oot),
  .sel_ref_i  (sel_ref_o),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .chg_i      (chg_bits),
  .int_bits_i (int_bits),
  .irq_en_i   (irq_en_i),
  .irq_i      (irq_o),
  .rd_data_i  (rd_data_o)
);

// File: tb/lol_monitor_test.sv
`timescale 1ns/1ps
module lol_monitor_test;
  localparam realtime SYS_PERIOD = 20.0;
  localparam realtime REF_HALF   = 5.0;
  localparam int      WLOG       = 11;
  localparam realtime WIN_NS     = (2.0 ** WLOG) * 2.0 * REF_HALF;

  logic       rec_clk = 1'b0, ref_clk = 1'b0, sys_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cond = 3'b000;
  logic       rd_en = 1'b0, rd_addr = 1'b0;
  logic [3:0] irq_en = 4'h0;
  logic [7:0] rd_data;
  logic       sel_ref, lol, irq;

  realtime rec_half = 5.0;
  bit      rec_run  = 1'b1;
  int      checks = 0, errors = 0;
  bit      done = 1'b0;

  typedef struct {
    string      req;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];
  logic  rd_seen = 1'b0;

  lol_monitor #(.WIN_LOG2(WLOG)) uut (
    .rec_clk_i (rec_clk),
    .ref_clk_i (ref_clk),
    .sys_clk_i (sys_clk),
    .rst_ni    (rst_n),
    .cond_i    (cond),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .irq_en_i  (irq_en),
    .rd_data_o (rd_data),
    .sel_ref_o (sel_ref),
    .lol_o     (lol),
    .irq_o     (irq)
  );

  initial forever #(SYS_PERIOD / 2.0) sys_clk = ~sys_clk;
  initial begin
    #1.0;
    forever #(REF_HALF) ref_clk = ~ref_clk;
  end
  initial forever begin
    #(rec_half);
    if (rec_run) rec_clk = ~rec_clk;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: issue a read, push expected data
  task automatic read_reg(input logic a, input logic [7:0] exp, input string req);
    @(negedge sys_clk);
    rd_en   = 1'b1;
    rd_addr = a;
    sb_q.push_back('{req, exp});
    @(negedge sys_clk);
    rd_en = 1'b0;
  endtask

  // monitor: data is valid after the edge that sampled rd_en
  always @(posedge sys_clk) rd_seen <= rd_en;
  always @(negedge sys_clk) begin
    if (rd_seen) begin
      item_t it;
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard: unexpected read data %0h expected none", rd_data);
      end else begin
        it = sb_q.pop_front();
        chk(it.req, rd_data, it.exp);
      end
    end
  end

  task automatic wait_win(input real n);
    #(n * WIN_NS);
    @(negedge sys_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * SYS_PERIOD);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(5 * SYS_PERIOD);
    rst_n = 1'b1;
    chk("R1 sel_ref", {7'd0, sel_ref}, 8'h00);
    chk("R1 lol", {7'd0, lol}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    read_reg(1'b0, 8'h00, "R1 status");
    read_reg(1'b1, 8'h00, "R1 int");

    wait_win(3.0);
    chk("R2 nominal sel_ref", {7'd0, sel_ref}, 8'h00);
    rec_half = 5.01;  // 0.2% slow
    wait_win(3.0);
    chk("R2 slight offset sel_ref", {7'd0, sel_ref}, 8'h00);
    read_reg(1'b1, 8'h00, "R2 int quiet");

    rec_half = 5.05;  // 1% slow
    wait_win(2.5);
    chk("R3 slow sel_ref", {7'd0, sel_ref}, 8'h01);
    chk("R3 slow lol", {7'd0, lol}, 8'h01);
    read_reg(1'b0, 8'h04, "R7 status lol bit");
    chk("R9 masked irq", {7'd0, irq}, 8'h00);
    irq_en = 4'b0100;
    repeat (3) @(negedge sys_clk);
    chk("R9 enabled irq", {7'd0, irq}, 8'h01);
    read_reg(1'b1, 8'h04, "R8 int on declare");
    read_reg(1'b1, 8'h00, "R8 int cleared by read");
    repeat (3) @(negedge sys_clk);
    chk("R9 irq after clear", {7'd0, irq}, 8'h00);

    rec_half = 5.0;
    wait_win(0.9);
    chk("R5 still declared after one window", {7'd0, sel_ref}, 8'h01);
    wait_win(2.6);
    chk("R5 cleared sel_ref", {7'd0, sel_ref}, 8'h00);
    chk("R5 cleared lol", {7'd0, lol}, 8'h00);
    chk("R8 irq on clearance", {7'd0, irq}, 8'h01);
    read_reg(1'b1, 8'h04, "R8 int on clearance");

    rec_run = 1'b0;
    wait_win(2.5);
    chk("R6 stopped clock sel_ref", {7'd0, sel_ref}, 8'h01);
    chk("R6 stopped clock lol", {7'd0, lol}, 8'h01);
    rec_run = 1'b1;
    wait_win(3.5);
    chk("R6 recovered sel_ref", {7'd0, sel_ref}, 8'h00);
    read_reg(1'b1, 8'h04, "R8 int after stop");

    rec_half = 4.95;  // 1% fast
    wait_win(2.5);
    chk("R3 fast sel_ref", {7'd0, sel_ref}, 8'h01);
    rec_half = 5.0;
    wait_win(3.5);
    chk("R5 fast recovered sel_ref", {7'd0, sel_ref}, 8'h00);
    read_reg(1'b1, 8'h04, "R8 int after fast");

    irq_en = 4'hf;
    cond = 3'b001;
    repeat (2) @(negedge sys_clk);
    read_reg(1'b0, 8'h01, "R7 status DMO bit0");
    read_reg(1'b1, 8'h01, "R8 int DMO bit0");
    cond = 3'b101;
    repeat (2) @(negedge sys_clk);
    read_reg(1'b0, 8'h09, "R7 status FL bit3");
    read_reg(1'b1, 8'h08, "R8 int FL bit3");
    cond = 3'b010;
    repeat (2) @(negedge sys_clk);
    read_reg(1'b0, 8'h02, "R7 status LOS bit1");
    read_reg(1'b1, 8'h0b, "R8 int falls and LOS");
    repeat (3) @(negedge sys_clk);
    chk("R9 irq after final clear", {7'd0, irq}, 8'h00);

    repeat (4) @(negedge sys_clk);
    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule